// File: doc/BRIEF.md
# Multiply Step Arithmetic Unit

This unit performs one step of a shift-and-add 32x32 multiplication in a single clock. Each step takes a 32-bit source word, a second operand that is either a register value or a sign-extended 13-bit immediate, the current 32-bit multiplier word Y and the current 8-bit condition-code byte. From these it forms a destination value, a new Y and a new condition-code byte.

In each step the source word is shifted right by one place. The vacated top bit is filled with the exclusive-OR of the incoming 32-bit negative and overflow flags. The second operand is added to this shifted word only when the low bit of Y is set. Y itself shifts right by one and takes the source word's low bit into its top. Software runs 32 such steps and then one final step with a zero operand, feeding each step's destination, Y and condition codes into the next. The results are registered and only update when a step is issued.

The condition-code byte has two 4-bit groups, each ordered {N, Z, V, C} from high bit to low: bits [3:0] describe the 32-bit result and bits [7:4] describe the 64-bit result.

Top module: `msu_unit`

## Requirements
- R1: The shifted partial product is {ccr_in[3] XOR ccr_in[1], src1[31:1]}, where ccr_in[3] is the 32-bit N flag and ccr_in[1] is the 32-bit V flag.
- R2: The addend equals the selected operand when y_in[0] is 1, and zero when y_in[0] is 0.
- R3: When imm_sel is 1 the operand is imm13 sign-extended from bit 12 to 32 bits. When imm_sel is 0 the operand is src2.
- R4: rd_out is the 64-bit sum of the partial product and the addend, each first sign-extended from 32 to 64 bits. Its low 32 bits therefore equal the 32-bit wrapped sum.
- R5: y_out becomes {src1[0], y_in[31:1]}.
- R6: ccr_out[0] (32-bit C) is the carry out of the unsigned 32-bit addition of the partial product and the addend.
- R7: ccr_out[1] (32-bit V) is 1 when both 32-bit addends have the same bit 31 and the 32-bit sum's bit 31 differs from it.
- R8: ccr_out[3] (32-bit N) is bit 31 of the result. ccr_out[2] (32-bit Z) is 1 exactly when rd_out[31:0] is zero.
- R9: ccr_out[4] (64-bit C) is the carry out of the unsigned 64-bit addition of the sign-extended addends. ccr_out[5] (64-bit V) is 1 when both extended addends share bit 63 and the sum's bit 63 differs from it.
- R10: ccr_out[7] (64-bit N) is rd_out[63]. ccr_out[6] (64-bit Z) is 1 exactly when all 64 bits of rd_out are zero.
- R11: rd_out, y_out and ccr_out load on the rising edge where step_valid is 1 and otherwise hold their value. rd_valid is 1 for exactly the cycle after each issued step.
- R12: While rst_n is low, rd_out, y_out, ccr_out and rd_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Issue one multiply step this cycle |
| src1 | input | 32 | Source word (running partial product) |
| src2 | input | 32 | Register operand |
| imm13 | input | 13 | Immediate operand |
| imm_sel | input | 1 | 1 selects the sign-extended immediate |
| y_in | input | 32 | Current multiplier word |
| ccr_in | input | 8 | Current condition codes {xN,xZ,xV,xC,iN,iZ,iV,iC} |
| rd_out | output | 64 | Registered destination value |
| rd_valid | output | 1 | Destination written in the previous cycle |
| y_out | output | 32 | Registered updated Y |
| ccr_out | output | 8 | Registered updated condition codes |

## Verification
On every cycle, the assertions check the behaviour of the register stage. They confirm that outputs hold while no step is issued and that rd_valid follows step_valid. They also check that the Y shift and the zero-addend case match the inputs that were sampled. Finally, they check that the N and Z flags of both groups agree with the registered destination value. Only the bench's scenarios can show the arithmetic content: carry and overflow at the 32-bit and 64-bit boundaries, immediate sign extension, the N XOR V fill bit, and a chained 33-step multiply in which each step consumes the previous outputs.

// File: rtl/msu_pkg.sv
package msu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  typedef struct packed {
    cc_t x;
    cc_t i;
  } ccr_t;
endpackage

// File: rtl/msu_operand.sv
module msu_operand #(
  parameter int WORD  = 32,
  parameter int IMM_W = 13
) (
  input  logic [WORD-1:0]  reg_val,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             imm_sel,
  output logic [WORD-1:0]  oper
);
  localparam int EXT_W = WORD - IMM_W;

  logic [WORD-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    oper    = imm_sel ? imm_ext : reg_val;
  end
endmodule

// File: rtl/msu_step_core.sv
module msu_step_core #(
  parameter int WORD = 32
) (
  input  logic [WORD-1:0] src1,
  input  logic [WORD-1:0] oper,
  input  logic [WORD-1:0] y_cur,
  input  logic            fill_bit,
  output logic [WORD-1:0] part,
  output logic [WORD-1:0] addend,
  output logic [WORD-1:0] y_next
);
  always_comb begin
    // shift the running product right, fill the top with N^V
    part   = {fill_bit, src1[WORD-1:1]};
    // conditional add controlled by the multiplier's low bit
    addend = y_cur[0] ? oper : '0;
    // multiplier shifts right, source LSB enters at the top
    y_next = {src1[0], y_cur[WORD-1:1]};
  end
endmodule

// File: rtl/msu_flags.sv
module msu_flags
  import msu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output cc_t          cc
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[W-1:0];
    cc.n = wide[W-1];
    cc.z = (wide[W-1:0] == '0);
    cc.v = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
    cc.c = wide[W];
  end
endmodule

// File: rtl/msu_unit.sv
module msu_unit
  import msu_pkg::*;
#(
  parameter int WORD  = 32,
  parameter int XWORD = 64,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic [WORD-1:0]  src1,
  input  logic [WORD-1:0]  src2,
  input  logic [IMM_W-1:0] imm13,
  input  logic             imm_sel,
  input  logic [WORD-1:0]  y_in,
  input  logic [7:0]       ccr_in,
  output logic [XWORD-1:0] rd_out,
  output logic             rd_valid,
  output logic [WORD-1:0]  y_out,
  output logic [7:0]       ccr_out
);
  localparam int HI_W = XWORD - WORD;

  logic [WORD-1:0]  oper;
  logic [WORD-1:0]  part;
  logic [WORD-1:0]  addend;
  logic [WORD-1:0]  y_next;
  logic             fill_bit;
  logic [XWORD-1:0] part_x;
  logic [XWORD-1:0] addend_x;
  logic [WORD-1:0]  sum_lo;
  logic [XWORD-1:0] sum_x;
  cc_t              cc_lo;
  cc_t              cc_x;
  ccr_t             ccr_next;
  logic [XWORD-1:0] rd_next;

  logic [XWORD-1:0] rd_d,  rd_q;
  logic [WORD-1:0]  y_d,   y_q;
  logic [7:0]       ccr_d, ccr_q;
  logic             vld_d, vld_q;

  msu_operand #(.WORD(WORD), .IMM_W(IMM_W)) u_oper (
    .reg_val (src2),
    .imm_val (imm13),
    .imm_sel (imm_sel),
    .oper    (oper)
  );

  assign fill_bit = ccr_in[3] ^ ccr_in[1];

  msu_step_core #(.WORD(WORD)) u_core (
    .src1     (src1),
    .oper     (oper),
    .y_cur    (y_in),
    .fill_bit (fill_bit),
    .part     (part),
    .addend   (addend),
    .y_next   (y_next)
  );

  assign part_x   = {{HI_W{part[WORD-1]}}, part};
  assign addend_x = {{HI_W{addend[WORD-1]}}, addend};

  msu_flags #(.W(WORD)) u_flags_lo (
    .a   (part),
    .b   (addend),
    .sum (sum_lo),
    .cc  (cc_lo)
  );

  msu_flags #(.W(XWORD)) u_flags_x (
    .a   (part_x),
    .b   (addend_x),
    .sum (sum_x),
    .cc  (cc_x)
  );

  always_comb begin
    ccr_next.i = cc_lo;
    ccr_next.x = cc_x;
    rd_next    = {sum_x[XWORD-1:WORD], sum_lo};
  end

  // next-state
  always_comb begin
    rd_d  = rd_q;
    y_d   = y_q;
    ccr_d = ccr_q;
    vld_d = step_valid;
    if (step_valid) begin
      rd_d  = rd_next;
      y_d   = y_next;
      ccr_d = ccr_next;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      y_q   <= '0;
      ccr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      y_q   <= y_d;
      ccr_q <= ccr_d;
      vld_q <= vld_d;
    end
  end

  assign rd_out   = rd_q;
  assign y_out    = y_q;
  assign ccr_out  = ccr_q;
  assign rd_valid = vld_q;

  // outputs hold while idle
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(rd_out) && $stable(y_out) && $stable(ccr_out)));

  assert_vld_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> rd_valid);

  assert_novld_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> !rd_valid);

  assert_yshift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> (y_out == {$past(src1[0]), $past(y_in[WORD-1:1])}));

  assert_noadd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !y_in[0]) |=>
      (rd_out[WORD-1:0] == {$past(ccr_in[3] ^ ccr_in[1]), $past(src1[WORD-1:1])}));

  assert_lo_nz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((ccr_out[2] == (rd_out[WORD-1:0] == '0)) &&
                  (ccr_out[3] == rd_out[WORD-1])));

  assert_x_nz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((ccr_out[6] == (rd_out == '0)) &&
                  (ccr_out[7] == rd_out[XWORD-1])));
endmodule

// File: tb/sim_msu_unit.sv
module sim_msu_unit;
  logic        clk;
  logic        rst_n;
  logic        step_valid;
  logic [31:0] src1, src2, y_in;
  logic [12:0] imm13;
  logic        imm_sel;
  logic [7:0]  ccr_in;
  logic [63:0] rd_out;
  logic        rd_valid;
  logic [31:0] y_out;
  logic [7:0]  ccr_out;

  int checks;
  int failures;
  bit done;

  msu_unit u0 (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
    .src1(src1), .src2(src2), .imm13(imm13), .imm_sel(imm_sel),
    .y_in(y_in), .ccr_in(ccr_in),
    .rd_out(rd_out), .rd_valid(rd_valid), .y_out(y_out), .ccr_out(ccr_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected-value models
  logic [63:0] e_rd;
  logic [31:0] e_y;
  logic [7:0]  e_ccr;

  function automatic void model(input logic [31:0] s1, input logic [31:0] s2,
                                input logic [12:0] im, input logic isel,
                                input logic [31:0] y, input logic [7:0] cc,
                                output logic [63:0] rd, output logic [31:0] yn,
                                output logic [7:0] ccn);
    logic [31:0] op, p, a;
    logic [32:0] s33;
    logic [64:0] s65;
    logic [63:0] px, ax;
    op  = isel ? {{19{im[12]}}, im} : s2;
    p   = {cc[3] ^ cc[1], s1[31:1]};
    a   = y[0] ? op : 32'd0;
    s33 = {1'b0, p} + {1'b0, a};
    px  = {{32{p[31]}}, p};
    ax  = {{32{a[31]}}, a};
    s65 = {1'b0, px} + {1'b0, ax};
    rd  = s65[63:0];
    yn  = {s1[0], y[31:1]};
    ccn[0] = s33[32];
    ccn[1] = (p[31] == a[31]) && (s33[31] != p[31]);
    ccn[2] = (s33[31:0] == 32'd0);
    ccn[3] = s33[31];
    ccn[4] = s65[64];
    ccn[5] = (px[63] == ax[63]) && (s65[63] != px[63]);
    ccn[6] = (s65[63:0] == 64'd0);
    ccn[7] = s65[63];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] s1, input logic [31:0] s2,
                      input logic [12:0] im, input logic isel,
                      input logic [31:0] y, input logic [7:0] cc);
    @(negedge clk);
    src1 = s1; src2 = s2; imm13 = im; imm_sel = isel; y_in = y; ccr_in = cc;
    step_valid = 1'b1;
    model(s1, s2, im, isel, y, cc, e_rd, e_y, e_ccr);
    @(negedge clk);
    step_valid = 1'b0;
    chk("R4 rd", rd_out, e_rd);
    chk("R5 y", {32'd0, y_out}, {32'd0, e_y});
    chk("R6 R7 R8 R9 R10 ccr", {56'd0, ccr_out}, {56'd0, e_ccr});
    chk("R11 rd_valid", {63'd0, rd_valid}, 64'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] h_rd;
    logic [31:0] h_y;
    logic [7:0]  h_cc;
    logic [31:0] mcand;
    logic [31:0] acc;
    logic [31:0] yv;
    logic [7:0]  ccv;
    int unsigned seed;
    checks = 0; failures = 0; done = 1'b0;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    rst_n = 1'b0; step_valid = 1'b0;
    src1 = '0; src2 = '0; imm13 = '0; imm_sel = 1'b0; y_in = '0; ccr_in = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rd", rd_out, 64'd0);
    chk("R12 y", {32'd0, y_out}, 64'd0);
    chk("R12 ccr", {56'd0, ccr_out}, 64'd0);
    chk("R12 vld", {63'd0, rd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 fill bit from N^V: N=1,V=0 -> fill 1; y0=0 so no add
    step(32'h0000_0003, 32'h1234_5678, 13'd0, 1'b0, 32'h8000_0000, 8'b0000_1000);
    chk("R1 fill", {32'd0, rd_out[31:0]}, {32'd0, 32'h8000_0001});
    // R1 N=1,V=1 -> fill 0
    step(32'hFFFF_FFFF, 32'd0, 13'd0, 1'b0, 32'd2, 8'b0000_1010);
    chk("R1 fill nv", {32'd0, rd_out[31:0]}, {32'd0, 32'h7FFF_FFFF});
    // R2 y0=0 -> zero addend
    step(32'h0000_0010, 32'hFFFF_FFFF, 13'd0, 1'b0, 32'hFFFF_FFFE, 8'd0);
    chk("R2 noadd", rd_out, 64'd8);
    // R3 immediate negative extremes
    step(32'd0, 32'h0, 13'h1000, 1'b1, 32'd1, 8'd0);
    chk("R3 imm min", rd_out, 64'hFFFF_FFFF_FFFF_F000);
    step(32'd0, 32'hDEAD_BEEF, 13'h0FFF, 1'b1, 32'd1, 8'd0);
    chk("R3 imm max", rd_out, 64'd4095);
    // R7 32-bit overflow: 0x7FFFFFFF + 1
    step(32'hFFFF_FFFE, 32'd1, 13'd0, 1'b0, 32'd1, 8'd0);
    chk("R7 V", {63'd0, ccr_out[1]}, 64'd1);
    // R6/R8 carry to zero: 0xFFFFFFFF + 1 with fill 1
    step(32'hFFFF_FFFE, 32'd1, 13'd0, 1'b0, 32'd1, 8'b0000_1000);
    chk("R6 C", {63'd0, ccr_out[0]}, 64'd1);
    chk("R8 Z", {63'd0, ccr_out[2]}, 64'd1);
    chk("R10 xZ", {63'd0, ccr_out[6]}, 64'd1);
    chk("R9 xC", {63'd0, ccr_out[4]}, 64'd1);

    // R11 hold: idle with changed inputs
    h_rd = rd_out; h_y = y_out; h_cc = ccr_out;
    @(negedge clk);
    src1 = 32'hA5A5_A5A5; src2 = 32'h5A5A_5A5A; y_in = 32'hFFFF_FFFF; ccr_in = 8'hFF;
    step_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 hold rd", rd_out, h_rd);
    chk("R11 hold y", {32'd0, y_out}, {32'd0, h_y});
    chk("R11 hold ccr", {56'd0, ccr_out}, {56'd0, h_cc});
    chk("R11 idle vld", {63'd0, rd_valid}, 64'd0);

    // random mix
    for (int k = 0; k < 300; k++) begin
      step($urandom, $urandom, 13'($urandom), 1'($urandom), $urandom, 8'($urandom));
    end

    // chained multiply: 32 steps + a final zero-operand step
    for (int t = 0; t < 4; t++) begin
      mcand = $urandom;
      acc = 32'd0; yv = $urandom; ccv = 8'd0;
      for (int s = 0; s < 33; s++) begin
        step(acc, (s == 32) ? 32'd0 : mcand, 13'd0, 1'b0, yv, ccv);
        acc = rd_out[31:0]; yv = y_out; ccv = ccr_out;
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule